// File: doc/BRIEF.md
# Pipelined No-Wait-State Synchronous SRAM

A small synchronous static RAM that can change the shared data bus from a read to a write, or from a write to a read, with no idle cycle between them. A single rising-edge clock registers every input. The host starts an access on one cycle. Read data goes out on the bus in the cycle after the next edge, and write data is taken from the bus at the same point, so both kinds of access fill the same bus slot. A command can therefore be issued on every cycle and keep the bus fully busy.

The host either loads a new command or lets the block continue the previous one. When it continues, a 2-bit burst counter inside the block steps the two low address bits, in a linear order or an interleaved order. Three chip selects must all be active for a loaded command to take effect. Otherwise the cycle is a deselect. Per-byte write enables mask which bytes of a word a write changes. A read that targets the word whose write data is arriving in the same edge gets the newly merged bytes. An active-low clock enable freezes every register in the block. The bus is modelled as separate input, output and output-enable ports.

Top module: `nowait_sram`

## Requirements
- R1: Reads and writes can alternate on every enabled cycle in any order, with no idle cycle between them, and every access still returns or stores the correct data.
- R2: For a command accepted at enabled edge k, read data is driven after edge k+1 and is valid at edge k+2. Write data for such a command is taken from `dq_in` at edge k+2.
- R3: While `clk_en_n` is 1, a clock edge changes nothing: `dq_out`, `dq_oe`, the burst state and the memory keep their values, and all other inputs are ignored.
- R4: When `adv_ld` is 0, a new command is loaded with address `addr`, and the burst count is set to 0. When `adv_ld` is 1, the previous command (read, write or deselect) continues at the next burst address, and `rw`, `addr` and the chip selects are ignored.
- R5: With `burst_lin` = 1, the low two address bits of the n-th access in a burst are (start + n) mod 4, where n is 0 to 3. The upper bits stay fixed.
- R6: With `burst_lin` = 0, the low two address bits of the n-th access in a burst are start XOR n. The upper bits stay fixed.
- R7: A loaded command is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Otherwise it is a deselect, which writes nothing and leaves `dq_oe` at 0 in its data slot.
- R8: `rw` = 1 reads and `rw` = 0 writes. On a write, byte i (bits i*BYTE_W upward) is updated only when `byte_we_n[i]` = 0. The byte enables are sampled with each address, including burst continuation cycles.
- R9: If a read is accepted one enabled edge after a write to the same word, the read returns the stored word with the bytes of that write merged in.
- R10: `dq_oe` is 1 exactly in the data slot of a selected read, and 0 in the data slots of writes and deselects.
- R11: After reset, `dq_oe` and `dq_out` are 0 and the pipeline holds no command. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low pipeline reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| adv_ld | input | 1 | 0 loads a new command, 1 continues the burst |
| rw | input | 1 | 1 read, 0 write (sampled on load) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| byte_we_n | input | BYTES | Active-low per-byte write enables |
| addr | input | ADDR_W | Word address (sampled on load) |
| dq_in | input | BYTES*BYTE_W | Bus value seen by the device (write data) |
| dq_out | output | BYTES*BYTE_W | Read data driven onto the bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The bench builds the block with ADDR_W = 4, BYTES = 2 and BYTE_W = 8. That gives a 16-word array, so the sweeps can reach every word. With this setup the bench can try every burst start position in both orders and every combination of the two byte enables at every address. It can also place a write directly before a read to the same word at every address. All of this runs while a bench model of the memory and of the two-slot pipeline predicts each bus slot.

// File: rtl/nws_pkg.sv
`timescale 1ns/1ps
package nws_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of burst step n from start s
  function automatic logic [1:0] burst_low(input logic [1:0] s,
                                           input logic [1:0] n,
                                           input logic       lin);
    return lin ? (s + n) : (s ^ n);
  endfunction

endpackage

// File: rtl/nws_ctrl.sv
`timescale 1ns/1ps
module nws_ctrl
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic              sel_ok,
  input  logic              lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  be,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [BYTES-1:0]  s2_be
);

  logic [ADDR_W-1:0] base_q, base_nx, addr_nx;
  logic [1:0]        cnt_q, cnt_nx;
  logic [BYTES-1:0]  s1_be;
  op_e               load_op, op_nx;

  // named events for the checks
  logic load_evt, step_evt;
  assign load_evt = en & ~adv_ld;
  assign step_evt = en & adv_ld;

  always_comb begin
    load_op = sel_ok ? (rw ? OP_READ : OP_WRITE) : OP_IDLE;
    cnt_nx  = adv_ld ? cnt_q + 2'd1 : 2'd0;
    base_nx = adv_ld ? base_q : addr;
    op_nx   = adv_ld ? s1_op : load_op;
    addr_nx = {base_nx[ADDR_W-1:2], burst_low(base_nx[1:0], cnt_nx, lin)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      base_q  <= base_nx;
      cnt_q   <= cnt_nx;
      s1_op   <= op_nx;
      s1_addr <= addr_nx;
      s1_be   <= be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assert_load_takes_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (s1_addr == $past(addr)));

  assert_step_keeps_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (s1_op == $past(s1_op)) &&
                 (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !sel_ok) |=> (s1_op == OP_IDLE));

  assert_freeze_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(s1_op) && $stable(s1_addr) && $stable(s2_op) && $stable(cnt_q));

endmodule

// File: rtl/nws_array.sv
`timescale 1ns/1ps
module nws_array
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [BYTES-1:0]        s2_be,
  input  logic [BYTES*BYTE_W-1:0] dq_in,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int W     = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [W-1:0] merge(input logic [W-1:0]     old_w,
                                         input logic [W-1:0]     new_w,
                                         input logic [BYTES-1:0] m);
    logic [W-1:0] r;
    r = old_w;
    for (int b = 0; b < BYTES; b++)
      if (m[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_raw, rd_word;

  // named events for the checks
  logic wr_evt, rd_evt, fwd_hit;
  assign wr_evt  = en && (s2_op == OP_WRITE);
  assign rd_evt  = en && (s1_op == OP_READ);
  assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (wr_evt) mem[s2_addr] <= merge(mem[s2_addr], dq_in, s2_be);
  end

  always_comb begin
    rd_raw  = mem[s1_addr];
    rd_word = fwd_hit ? merge(rd_raw, dq_in, s2_be) : rd_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else if (en) begin
      dq_oe <= (s1_op == OP_READ);
      if (s1_op == OP_READ) dq_out <= rd_word;
    end
  end

  assert_oe_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> dq_oe);

  assert_oe_off_other_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s1_op != OP_READ) |=> !dq_oe);

  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dq_out) && $stable(dq_oe));

  assert_forward_low_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && fwd_hit && s2_be[0]) |=> (dq_out[BYTE_W-1:0] == $past(dq_in[BYTE_W-1:0])));

endmodule

// File: rtl/nowait_sram.sv
`timescale 1ns/1ps
module nowait_sram
  import nws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    adv_ld,
  input  logic                    rw,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    burst_lin,
  input  logic [BYTES-1:0]        byte_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] dq_in,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  logic              en, sel_ok;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s2_be;

  assign en     = ~clk_en_n;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  nws_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .adv_ld(adv_ld), .rw(rw),
    .sel_ok(sel_ok), .lin(burst_lin), .addr(addr), .be(~byte_we_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_be(s2_be)
  );

  nws_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .en(en), .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: tb/nowait_sram_bench.sv
`timescale 1ns/1ps
module nowait_sram_bench;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int W  = NB * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic clk_en_n, adv_ld, rw, sel_a_n, sel_b, sel_c_n, burst_lin, dq_oe;
  logic [NB-1:0] byte_we_n;
  logic [AW-1:0] addr;
  logic [W-1:0]  dq_in, dq_out;

  nowait_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_nowait_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld), .rw(rw),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_lin(burst_lin),
    .byte_we_n(byte_we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe)
  );

  int n_run = 0, n_fail = 0, wseq = 0, ncyc = 0;
  string cur_req = "R2";
  logic [W-1:0] model [16];
  // bench pipeline: index 0 = accepted last edge, 1 = the one before; 0 idle, 1 read, 2 write
  int            p_op [2];
  logic [AW-1:0] p_addr [2];
  logic [NB-1:0] p_wen [2];
  int            b_op = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  logic [W-1:0]  last_out = '0;
  logic          last_oe = 1'b0;
  bit            last_en = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit adv, input bit rwv, input logic [2:0] selv,
                      input logic [NB-1:0] wn, input logic [AW-1:0] a, input bit lin);
    logic [W-1:0]  d;
    logic [AW-1:0] na;
    @(negedge clk);
    ncyc++;
    if (p_op[1] == 1) begin
      chk(dq_oe === 1'b1, "R10", "oe in read slot", {{(W-1){1'b0}}, dq_oe}, 1);
      chk(dq_out === model[p_addr[1]], cur_req, "read data", dq_out, model[p_addr[1]]);
    end else begin
      chk(dq_oe === 1'b0, "R10", "oe outside read slot", {{(W-1){1'b0}}, dq_oe}, 0);
    end
    if (!last_en) begin
      chk(dq_out === last_out, "R3", "dq_out held", dq_out, last_out);
      chk(dq_oe === last_oe, "R3", "dq_oe held", {{(W-1){1'b0}}, dq_oe}, {{(W-1){1'b0}}, last_oe});
    end
    last_out = dq_out;
    last_oe  = dq_oe;
    last_en  = en;
    clk_en_n = !en;
    adv_ld   = adv;
    rw       = rwv;
    {sel_a_n, sel_b, sel_c_n} = selv;
    byte_we_n = wn;
    addr      = a;
    burst_lin = lin;
    if (en && p_op[1] == 2) begin
      d = W'(int'(p_addr[1]) * 32'h3B1 + wseq * 32'h1F7 + 32'h5A);
      wseq++;
      dq_in = d;
      for (int b = 0; b < NB; b++)
        if (!p_wen[1][b]) model[p_addr[1]][b*BW +: BW] = d[b*BW +: BW];
    end else begin
      dq_in = W'(32'hC3A5 ^ (ncyc * 32'h0101));
    end
    if (en) begin
      if (!adv) begin
        b_cnt  = 2'd0;
        b_base = a;
        b_op   = (selv == 3'b010) ? (rwv ? 1 : 2) : 0;
      end else begin
        b_cnt = b_cnt + 2'd1;
      end
      if (lin) na = (b_base & 4'hC) | ((b_base + AW'(b_cnt)) & 4'h3);
      else     na = {b_base[3:2], b_base[1:0] ^ b_cnt};
      @(posedge clk);
      p_op[1] = p_op[0];  p_addr[1] = p_addr[0];  p_wen[1] = p_wen[0];
      p_op[0] = b_op;     p_addr[0] = na;         p_wen[0] = wn;
    end else begin
      @(posedge clk);
    end
  endtask

  task automatic ld(input bit rwv, input logic [AW-1:0] a, input logic [NB-1:0] wn, input bit lin);
    step(1'b1, 1'b0, rwv, 3'b010, wn, a, lin);
  endtask
  // continuation: rw, addr and selects set to values that would matter on a load
  task automatic adv_c(input logic [NB-1:0] wn, input bit lin);
    step(1'b1, 1'b1, 1'b0, 3'b111, wn, 4'hF, lin);
  endtask
  task automatic nop();
    step(1'b1, 1'b0, 1'b0, 3'b110, 2'b00, 4'h0, 1'b1);
  endtask
  task automatic stall(input bit adv);
    step(1'b0, adv, 1'b0, 3'b010, 2'b00, 4'h9, 1'b1);
  endtask

  initial begin
    p_op[0] = 0; p_op[1] = 0;
    p_addr[0] = '0; p_addr[1] = '0;
    p_wen[0] = '1; p_wen[1] = '1;
    clk_en_n = 1'b0; adv_ld = 1'b0; rw = 1'b1;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1; burst_lin = 1'b1;
    byte_we_n = '1; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk(dq_oe === 1'b0, "R11", "oe after reset", {{(W-1){1'b0}}, dq_oe}, 0);
    chk(dq_out === '0, "R11", "dq_out after reset", dq_out, '0);

    // R2: fill every word, then read them back-to-back
    cur_req = "R2";
    for (int a = 0; a < 16; a++) ld(1'b0, AW'(a), 2'b00, 1'b1);
    for (int a = 0; a < 16; a++) ld(1'b1, AW'(a), 2'b00, 1'b1);
    nop(); nop();

    // R8: every byte-enable pattern at every word, read back later
    cur_req = "R8";
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) ld(1'b0, AW'(a), NB'(m), 1'b1);
      for (int a = 0; a < 16; a++) ld(1'b1, AW'(a), 2'b00, 1'b1);
    end
    nop(); nop();

    // R9: read right after a masked write to the same word
    cur_req = "R9";
    for (int a = 0; a < 16; a++) begin
      ld(1'b0, AW'(a), NB'(a % 4), 1'b1);
      ld(1'b1, AW'(a), 2'b00, 1'b1);
    end
    nop(); nop();

    // R1: alternating W/R and R/W at different words, no gaps
    cur_req = "R1";
    for (int i = 0; i < 16; i++) begin
      ld(1'b1, AW'((i * 5) % 16), 2'b00, 1'b1);
      ld(1'b0, AW'((i * 7 + 3) % 16), 2'b00, 1'b1);
      ld(1'b1, AW'((i * 7 + 3) % 16), 2'b00, 1'b1);
    end
    nop(); nop();

    // R5 / R6: read bursts from every start, both orders (R4: continuation ignores rw/addr/selects)
    for (int lin = 1; lin >= 0; lin--) begin
      cur_req = (lin == 1) ? "R5" : "R6";
      for (int s = 0; s < 16; s++) begin
        ld(1'b1, AW'(s), 2'b00, lin[0]);
        adv_c(2'b00, lin[0]); adv_c(2'b00, lin[0]); adv_c(2'b00, lin[0]);
      end
    end
    nop(); nop();

    // R4: write bursts with per-step byte enables, read back linearly
    cur_req = "R4";
    ld(1'b0, 4'hA, 2'b00, 1'b0);
    adv_c(2'b01, 1'b0); adv_c(2'b10, 1'b0); adv_c(2'b00, 1'b0);
    ld(1'b0, 4'h7, 2'b10, 1'b1);
    adv_c(2'b00, 1'b1); adv_c(2'b01, 1'b1); adv_c(2'b11, 1'b1);
    ld(1'b1, 4'h8, 2'b00, 1'b1);
    adv_c(2'b00, 1'b1); adv_c(2'b00, 1'b1); adv_c(2'b00, 1'b1);
    ld(1'b1, 4'h4, 2'b00, 1'b1);
    adv_c(2'b00, 1'b1); adv_c(2'b00, 1'b1); adv_c(2'b00, 1'b1);
    nop(); nop();

    // R7: each select inactive in turn; write attempts and their continuations do nothing
    cur_req = "R7";
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 1'b0, 3'b010 ^ (3'b001 << k), 2'b00, 4'h3, 1'b1);
      adv_c(2'b00, 1'b1);
      ld(1'b1, 4'h3, 2'b00, 1'b1);
      ld(1'b1, 4'h0, 2'b00, 1'b1);
      nop(); nop();
    end

    // R3: stalls inside a mixed stream; stalled edges carry write-like inputs
    cur_req = "R3";
    ld(1'b0, 4'h2, 2'b00, 1'b1); stall(1'b0); stall(1'b1);
    ld(1'b1, 4'h2, 2'b00, 1'b1); stall(1'b0);
    ld(1'b0, 4'h7, 2'b01, 1'b1); stall(1'b0); stall(1'b0);
    ld(1'b1, 4'h7, 2'b00, 1'b1); stall(1'b1);
    ld(1'b1, 4'h9, 2'b00, 1'b1); stall(1'b0); stall(1'b0);
    adv_c(2'b00, 1'b1); stall(1'b1); adv_c(2'b00, 1'b1);
    nop(); stall(1'b0); nop(); nop();
    ld(1'b1, 4'h9, 2'b00, 1'b1);
    nop(); nop(); nop();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule